// File: doc/BRIEF.md
# Instruction Breakpoint Debug Unit

This unit sits next to the fetch and issue path of a processor core. The PC of each instruction about to execute is presented to it with a valid strobe, along with two flags from decode. One flag marks a normal software break instruction and the other marks the narrow (short-encoding) form. The unit holds a small bank of hardware breakpoint address registers and an enable mask. It also holds the processor status register and the debug-level cause, saved-PC and saved-status registers. All of these are reachable through a special-register (SR) write port and a combinational SR read port.

Debug events are only honoured while the current interrupt level is strictly below the configured debug level. A hardware match is checked before the instruction runs, so it preempts the instruction and wins over any break flag on the same PC. When an exception is taken, the unit saves the PC and the old status into the registers for the debug level. It records the cause and rewrites the status so that its level equals the debug level and its exception-mode bit is set. This masks further debug events until software lowers the level. The fetch unit is told through a one-cycle pulse that carries the captured PC and cause.

The control is a two-state machine:
- WATCH: instructions are examined.
- TAKEN: the cycle in which the exception pulse is driven. Instructions presented in this cycle are discarded.

Its transitions are:
- WATCH to TAKEN when an event fires.
- TAKEN to WATCH unconditionally.
- WATCH to WATCH otherwise.

Top module: `ibrk_debug_unit`

## Requirements
- R1: After reset the enable mask (SR 96) reads 0, the status register (SR 230) reads 0x10 (level 0, exception-mode bit 4 set), and `dbg_take` is low.
- R2: A write to SR 96 keeps only the low N_BRK bits; higher bits read back as zero.
- R3: Breakpoint address register i is SR 128+i. A write to 128+i with i at or beyond N_BRK is ignored: that number reads back 0 and no breakpoint fires at the written address.
- R4: When enable bit i is set, address register i equals `pc`, `pc_valid` is high and the level (status bits [3:0]) is below DBG_LEVEL, `dbg_take` rises in the following cycle. In that cycle `dbg_pc` equals the PC and cause bit 0 is set.
- R5: With several matching enabled breakpoints, the lowest index wins and is reported in cause bits [11:8]. A match preempts a break flag on the same instruction, and exactly one cause bit among [2:0] is set.
- R6: When the level is at or above DBG_LEVEL, no breakpoint fires and both break flags have no effect.
- R7: A normal break flag takes the exception with cause 0x002 and a narrow break flag with cause 0x004. If both flags are set, the normal one wins.
- R8: On taking, SR 233 receives the cause and SR 176+DBG_LEVEL receives the PC. SR 192+DBG_LEVEL receives the old status. The status keeps every other field, with bits [3:0] set to DBG_LEVEL and bit 4 set.
- R9: `dbg_take` is a one-cycle pulse, and at most one exception is raised per instruction.
- R10: SR 230 is writable, so software can lower the level and re-enable debug events.
- R11: A breakpoint whose enable bit is clear never fires, even when its address matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_valid | input | 1 | An instruction is about to execute at `pc` |
| pc | input | DATA_W | PC of that instruction |
| brk_insn | input | 1 | The instruction is a normal break |
| brk_narrow | input | 1 | The instruction is a narrow break |
| sr_wr_en | input | 1 | SR write strobe |
| sr_wr_num | input | 8 | SR number written |
| sr_wr_data | input | DATA_W | SR write data |
| sr_rd_num | input | 8 | SR number read |
| sr_rd_data | output | DATA_W | SR read data, 0 for unmapped numbers |
| dbg_take | output | 1 | One-cycle debug exception pulse |
| dbg_pc | output | DATA_W | PC captured for the exception |
| dbg_cause | output | CAUSE_W | Cause captured for the exception |

## Verification
The bench goes after the level gate at its boundary: level 5 must fire and levels 6 and 7 must not. A design using a less-or-equal compare would fire at level 6, or it would lock itself out after its own exception never lowers. Two breakpoints are set to the same address to catch a priority encoder that lets the highest index win, which would show as index 1 in the cause. A match is also combined with a break flag, which a design without preemption would report with the wrong cause. Writes to a breakpoint number beyond the bank and wide enable writes catch decoders that alias or keep stray bits. The status rewrite is checked with non-level bits set, so a design that clears the whole register is exposed through the saved and current status values.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;
    localparam int LVL_W     = 4;
    localparam int EXCM_BIT  = 4;
    localparam int CAUSE_W   = 12;
    localparam int C_IBRK    = 0;
    localparam int C_BRK     = 1;
    localparam int C_BRKN    = 2;
    localparam int C_IDX_LSB = 8;
    localparam int C_IDX_W   = 4;

    localparam logic [7:0] SR_ENABLE   = 8'd96;
    localparam logic [7:0] SR_ADDR0    = 8'd128;
    localparam logic [7:0] SR_PS       = 8'd230;
    localparam logic [7:0] SR_CAUSE    = 8'd233;
    localparam logic [7:0] SR_EPC_BASE = 8'd176;
    localparam logic [7:0] SR_EPS_BASE = 8'd192;

    localparam logic [31:0] PS_RESET = 32'h0000_0010;

    typedef enum logic {
        ST_WATCH,
        ST_TAKEN
    } dbg_state_e;
endpackage

// File: rtl/ibrk_regs.sv
module ibrk_regs
    import ibrk_pkg::*;
#(
    parameter int N_BRK  = 2,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              wr_num,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [N_BRK-1:0]        en_mask,
    output logic [N_BRK*DATA_W-1:0] addr_flat
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_mask <= '0;
        end else if (wr_en && wr_num == SR_ENABLE) begin
            en_mask <= wr_data[N_BRK-1:0];
        end
    end

    for (genvar g = 0; g < N_BRK; g++) begin : g_addr
        logic [DATA_W-1:0] addr_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q <= '0;
            end else if (wr_en && wr_num == SR_ADDR0 + 8'(g)) begin
                addr_q <= wr_data;
            end
        end
        assign addr_flat[g*DATA_W +: DATA_W] = addr_q;
    end
endmodule

// File: rtl/ibrk_match.sv
module ibrk_match #(
    parameter int N_BRK  = 2,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 1
) (
    input  logic [N_BRK-1:0]        en_mask,
    input  logic [N_BRK*DATA_W-1:0] addr_flat,
    input  logic [DATA_W-1:0]       pc,
    output logic                    hit,
    output logic [IDX_W-1:0]        hit_idx
);
    logic [N_BRK-1:0] match;

    for (genvar g = 0; g < N_BRK; g++) begin : g_cmp
        assign match[g] = en_mask[g] && (addr_flat[g*DATA_W +: DATA_W] == pc);
    end

    // Scan from the top down so the lowest matching index is left standing.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N_BRK - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/ibrk_dbg_ctrl.sv
module ibrk_dbg_ctrl
    import ibrk_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int DBG_LEVEL = 6,
    parameter int IDX_W     = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pc_valid,
    input  logic [DATA_W-1:0]  pc,
    input  logic               brk_insn,
    input  logic               brk_narrow,
    input  logic               bp_hit,
    input  logic [IDX_W-1:0]   bp_idx,
    input  logic               ps_wr_en,
    input  logic [DATA_W-1:0]  ps_wr_data,
    output logic [DATA_W-1:0]  ps_q,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [DATA_W-1:0]  epc_q,
    output logic [DATA_W-1:0]  eps_q,
    output logic               dbg_take,
    output logic [DATA_W-1:0]  dbg_pc,
    output logic [CAUSE_W-1:0] dbg_cause
);
    localparam logic [LVL_W-1:0] LVL = LVL_W'(DBG_LEVEL);

    dbg_state_e         state_q, state_d;
    logic               level_ok;
    logic               fire;
    logic [CAUSE_W-1:0] cause_d;
    logic [DATA_W-1:0]  ps_taken;

    assign level_ok = ps_q[LVL_W-1:0] < LVL;
    assign fire     = (state_q == ST_WATCH) && pc_valid && level_ok &&
                      (bp_hit || brk_insn || brk_narrow);

    always_comb begin
        cause_d = '0;
        if (bp_hit) begin
            cause_d[C_IBRK] = 1'b1;
            cause_d[C_IDX_LSB +: C_IDX_W] = C_IDX_W'(bp_idx);
        end else if (brk_insn) begin
            cause_d[C_BRK] = 1'b1;
        end else begin
            cause_d[C_BRKN] = 1'b1;
        end
    end

    always_comb begin
        ps_taken = ps_q;
        ps_taken[LVL_W-1:0] = LVL;
        ps_taken[EXCM_BIT]  = 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WATCH: state_d = fire ? ST_TAKEN : ST_WATCH;
            ST_TAKEN: state_d = ST_WATCH;
            default:  state_d = ST_WATCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WATCH;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q    <= DATA_W'(PS_RESET);
            cause_q <= '0;
            epc_q   <= '0;
            eps_q   <= '0;
        end else if (fire) begin
            cause_q <= cause_d;
            epc_q   <= pc;
            eps_q   <= ps_q;
            ps_q    <= ps_taken;
        end else if (ps_wr_en) begin
            ps_q    <= ps_wr_data;
        end
    end

    always_comb begin
        dbg_take  = (state_q == ST_TAKEN);
        dbg_pc    = epc_q;
        dbg_cause = cause_q;
    end
endmodule

// File: rtl/ibrk_debug_unit.sv
module ibrk_debug_unit
    import ibrk_pkg::*;
#(
    parameter int N_BRK     = 2,
    parameter int DATA_W    = 32,
    parameter int DBG_LEVEL = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pc_valid,
    input  logic [DATA_W-1:0]  pc,
    input  logic               brk_insn,
    input  logic               brk_narrow,
    input  logic               sr_wr_en,
    input  logic [7:0]         sr_wr_num,
    input  logic [DATA_W-1:0]  sr_wr_data,
    input  logic [7:0]         sr_rd_num,
    output logic [DATA_W-1:0]  sr_rd_data,
    output logic               dbg_take,
    output logic [DATA_W-1:0]  dbg_pc,
    output logic [CAUSE_W-1:0] dbg_cause
);
    localparam int IDX_W = (N_BRK > 1) ? $clog2(N_BRK) : 1;
    localparam logic [7:0] SR_EPC = SR_EPC_BASE + 8'(DBG_LEVEL);
    localparam logic [7:0] SR_EPS = SR_EPS_BASE + 8'(DBG_LEVEL);

    logic [N_BRK-1:0]        en_mask;
    logic [N_BRK*DATA_W-1:0] addr_flat;
    logic                    bp_hit;
    logic [IDX_W-1:0]        bp_idx;
    logic [DATA_W-1:0]       ps_q, epc_q, eps_q;
    logic [CAUSE_W-1:0]      cause_q;

    ibrk_regs #(.N_BRK(N_BRK), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sr_wr_en),
        .wr_num    (sr_wr_num),
        .wr_data   (sr_wr_data),
        .en_mask   (en_mask),
        .addr_flat (addr_flat)
    );

    ibrk_match #(.N_BRK(N_BRK), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_match (
        .en_mask   (en_mask),
        .addr_flat (addr_flat),
        .pc        (pc),
        .hit       (bp_hit),
        .hit_idx   (bp_idx)
    );

    ibrk_dbg_ctrl #(.DATA_W(DATA_W), .DBG_LEVEL(DBG_LEVEL), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_valid   (pc_valid),
        .pc         (pc),
        .brk_insn   (brk_insn),
        .brk_narrow (brk_narrow),
        .bp_hit     (bp_hit),
        .bp_idx     (bp_idx),
        .ps_wr_en   (sr_wr_en && sr_wr_num == SR_PS),
        .ps_wr_data (sr_wr_data),
        .ps_q       (ps_q),
        .cause_q    (cause_q),
        .epc_q      (epc_q),
        .eps_q      (eps_q),
        .dbg_take   (dbg_take),
        .dbg_pc     (dbg_pc),
        .dbg_cause  (dbg_cause)
    );

    always_comb begin
        sr_rd_data = '0;
        if (sr_rd_num == SR_ENABLE) sr_rd_data = DATA_W'(en_mask);
        if (sr_rd_num == SR_PS)     sr_rd_data = ps_q;
        if (sr_rd_num == SR_CAUSE)  sr_rd_data = DATA_W'(cause_q);
        if (sr_rd_num == SR_EPC)    sr_rd_data = epc_q;
        if (sr_rd_num == SR_EPS)    sr_rd_data = eps_q;
        for (int i = 0; i < N_BRK; i++) begin
            if (sr_rd_num == SR_ADDR0 + 8'(i)) sr_rd_data = addr_flat[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/ibrk_debug_chk.sv
module ibrk_debug_chk
    import ibrk_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int DBG_LEVEL = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pc_valid,
    input logic               dbg_take,
    input logic [CAUSE_W-1:0] dbg_cause,
    input logic [DATA_W-1:0]  ps_q,
    input logic [DATA_W-1:0]  eps_q
);
    // R9
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_take |=> !dbg_take);

    // R4
    take_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_take |-> $past(pc_valid));

    // R5
    one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_take |-> $countones(dbg_cause[2:0]) == 1);

    // R8
    take_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_take |-> (ps_q[LVL_W-1:0] == LVL_W'(DBG_LEVEL)) && ps_q[EXCM_BIT]);

    // R8
    take_eps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_take |-> eps_q == $past(ps_q));

    // R6
    gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_valid && ps_q[LVL_W-1:0] >= LVL_W'(DBG_LEVEL)) |=> !dbg_take);
endmodule

bind ibrk_debug_unit ibrk_debug_chk #(.DATA_W(DATA_W), .DBG_LEVEL(DBG_LEVEL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_valid  (pc_valid),
    .dbg_take  (dbg_take),
    .dbg_cause (dbg_cause),
    .ps_q      (ps_q),
    .eps_q     (eps_q)
);

// File: tb/tb_ibrk_debug_unit.sv
module tb_ibrk_debug_unit;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pc_valid = 1'b0;
    logic [DW-1:0] pc = '0;
    logic          brk_insn = 1'b0;
    logic          brk_narrow = 1'b0;
    logic          sr_wr_en = 1'b0;
    logic [7:0]    sr_wr_num = '0;
    logic [DW-1:0] sr_wr_data = '0;
    logic [7:0]    sr_rd_num = '0;
    logic [DW-1:0] sr_rd_data;
    logic          dbg_take;
    logic [DW-1:0] dbg_pc;
    logic [11:0]   dbg_cause;

    int checks = 0;
    int fails  = 0;
    logic [DW-1:0] ps_model = 32'h10;

    logic          q_take[$];
    logic [DW-1:0] q_pc[$];
    logic [11:0]   q_cause[$];
    string         q_req[$];

    always #5 clk = ~clk;

    ibrk_debug_unit dut (
        .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc(pc),
        .brk_insn(brk_insn), .brk_narrow(brk_narrow),
        .sr_wr_en(sr_wr_en), .sr_wr_num(sr_wr_num), .sr_wr_data(sr_wr_data),
        .sr_rd_num(sr_rd_num), .sr_rd_data(sr_rd_data),
        .dbg_take(dbg_take), .dbg_pc(dbg_pc), .dbg_cause(dbg_cause)
    );

    function automatic logic [DW-1:0] take_ps(input logic [DW-1:0] old);
        return (old & ~32'h1F) | 32'h16;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: one expected item per issued instruction, checked right after the edge.
    always @(posedge clk) begin
        #1;
        if (q_take.size() > 0) begin
            logic          et;
            logic [DW-1:0] ep;
            logic [11:0]   ec;
            string         er;
            et = q_take.pop_front();
            ep = q_pc.pop_front();
            ec = q_cause.pop_front();
            er = q_req.pop_front();
            check({er, " take"}, DW'(dbg_take), DW'(et));
            if (et) begin
                check({er, " pc"}, dbg_pc, ep);
                check({er, " cause"}, DW'(dbg_cause), DW'(ec));
            end
        end
    end

    task automatic issue(input logic [DW-1:0] a, input logic b, input logic n,
                         input logic et, input logic [11:0] ec, input string req);
        @(negedge clk);
        pc_valid = 1'b1; pc = a; brk_insn = b; brk_narrow = n;
        q_take.push_back(et); q_pc.push_back(a); q_cause.push_back(ec); q_req.push_back(req);
        @(negedge clk);
        pc_valid = 1'b0; brk_insn = 1'b0; brk_narrow = 1'b0;
        @(negedge clk);
        if (et) ps_model = take_ps(ps_model);
    endtask

    task automatic sr_write(input logic [7:0] num, input logic [DW-1:0] data);
        @(negedge clk);
        sr_wr_en = 1'b1; sr_wr_num = num; sr_wr_data = data;
        @(negedge clk);
        sr_wr_en = 1'b0;
        if (num == 8'd230) ps_model = data;
    endtask

    task automatic sr_check(input string req, input logic [7:0] num, input logic [DW-1:0] exp);
        sr_rd_num = num;
        #1;
        check(req, sr_rd_data, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        sr_check("R1 enable", 8'd96, 32'h0);
        sr_check("R1 status", 8'd230, 32'h10);
        check("R1 take", DW'(dbg_take), 32'h0);

        // R2 enable keeps only low N_BRK bits
        sr_write(8'd96, 32'hFFFF_FFFF);
        sr_check("R2 enable mask", 8'd96, 32'h3);

        // R3 address bank, out-of-range index ignored
        sr_write(8'd128, 32'h100);
        sr_write(8'd129, 32'h200);
        sr_write(8'd130, 32'h300);
        sr_check("R3 addr0", 8'd128, 32'h100);
        sr_check("R3 addr1", 8'd129, 32'h200);
        sr_check("R3 addr2 absent", 8'd130, 32'h0);

        sr_write(8'd96, 32'h1);
        issue(32'h200, 1'b0, 1'b0, 1'b0, 12'h0, "R11 disabled match");
        issue(32'h300, 1'b0, 1'b0, 1'b0, 12'h0, "R3 ignored address");
        // R4 enabled match
        issue(32'h100, 1'b0, 1'b0, 1'b1, 12'h001, "R4 match");
        // R8 state update
        sr_check("R8 saved pc", 8'd182, 32'h100);
        sr_check("R8 saved status", 8'd198, 32'h10);
        sr_check("R8 status", 8'd230, ps_model);
        sr_check("R8 cause", 8'd233, 32'h001);
        // R9 pulse has ended
        check("R9 pulse low", DW'(dbg_take), 32'h0);

        // R6 level at debug level: all events masked
        issue(32'h100, 1'b0, 1'b0, 1'b0, 12'h0, "R6 match masked");
        issue(32'h44, 1'b1, 1'b0, 1'b0, 12'h0, "R6 break masked");
        issue(32'h48, 1'b0, 1'b1, 1'b0, 12'h0, "R6 narrow masked");

        // R10 lower to 5, just below the debug level
        sr_write(8'd230, 32'h5);
        issue(32'h100, 1'b0, 1'b0, 1'b1, 12'h001, "R10 level 5 fires");
        sr_check("R8 saved status lvl5", 8'd198, 32'h5);
        sr_write(8'd230, 32'h7);
        issue(32'h100, 1'b0, 1'b0, 1'b0, 12'h0, "R6 level 7 masked");

        // R5 lowest index wins, match preempts break flag
        sr_write(8'd230, 32'hA0);
        sr_write(8'd128, 32'h500);
        sr_write(8'd129, 32'h500);
        sr_write(8'd96, 32'h3);
        issue(32'h500, 1'b1, 1'b0, 1'b1, 12'h001, "R5 lowest index");
        sr_check("R8 other fields kept", 8'd230, 32'hB6);
        sr_write(8'd230, 32'h0);
        sr_write(8'd96, 32'h2);
        issue(32'h500, 1'b0, 1'b0, 1'b1, 12'h101, "R5 index 1");

        // R7 break flags
        sr_write(8'd230, 32'h0);
        issue(32'h44, 1'b1, 1'b0, 1'b1, 12'h002, "R7 break");
        sr_check("R7 saved pc", 8'd182, 32'h44);
        sr_write(8'd230, 32'h0);
        issue(32'h48, 1'b0, 1'b1, 1'b1, 12'h004, "R7 narrow");
        sr_write(8'd230, 32'h0);
        issue(32'h4C, 1'b1, 1'b1, 1'b1, 12'h002, "R7 both flags");
        sr_check("R7 cause reg", 8'd233, 32'h002);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule